// File: doc/BRIEF.md
# Dual-Mode I/O Address Translator

This block sits between a CPU-side request port and a downstream I/O bus. Requests whose address falls in an 8 MB window are turned into I/O port accesses. A single level input chooses how the window offset becomes a port number. In the contiguous map, the low 16 bits of the address are the port. In the sparse map, every 4 KB CPU page exposes 32 bytes of ports, and these 32-byte groups are packed back to back into a dense 64 KB port space.

The resulting port number is added to a fixed I/O base before it goes out. Accesses carry 1, 2 or 4 bytes of little-endian data in the low lanes. Any byte alignment is accepted. Read responses from the I/O bus are passed back with the lanes above the access size cleared.

An access of any other size is refused with a one-cycle error pulse and is not issued downstream. The block holds no queue: each accepted request appears on the I/O bus on the following cycle. The map in force is the one on the mode input in the request's own cycle.

Top module: `dio_xlate`

## Requirements
- R1: With `map_sparse` low, an accepted request yields `io_addr` = 0x8000_0000 + `req_addr[15:0]`.
- R2: With `map_sparse` high, an accepted request yields `io_addr` = 0x8000_0000 + (`req_addr[22:12]` × 32 + `req_addr[4:0]`); address bits 11:5 have no effect on the port.
- R3: The map is taken from `map_sparse` in the cycle the request is presented. A new level applies to the very next request. Changing the level after a request has been accepted does not alter the access it produced.
- R4: `req_size` is a byte count (1, 2 or 4). `io_size` repeats it. `io_wdata` carries `req_wdata` with every byte lane at or above the size cleared.
- R5: A request in the window with any other size (0, 3, 5, 6, 7) raises `err` for one cycle, one cycle after the request, and issues no I/O access.
- R6: Unaligned accesses are accepted: the low address bits pass into the port unchanged for every legal size.
- R7: A request whose address lies outside 0x8000_0000 to 0x807F_FFFF produces neither an I/O access nor an error.
- R8: A read response (`io_rvalid`) is returned on `rsp_valid` one cycle later. `rsp_data` holds `io_rdata` masked to the size of the last issued read.
- R9: While reset is held, `io_valid`, `err` and `rsp_valid` are low.
- R10: An accepted request drives `io_valid` high for exactly the one cycle after it, with `io_write` equal to `req_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_sparse | input | 1 | Map select: 0 contiguous, 1 sparse |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 32 | CPU byte address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, little-endian in low lanes |
| io_valid | output | 1 | I/O access issued this cycle |
| io_write | output | 1 | I/O access direction |
| io_addr | output | 32 | I/O address, base plus port |
| io_size | output | 3 | I/O access size in bytes |
| io_wdata | output | 32 | Masked write data |
| io_rvalid | input | 1 | Read data returned by the I/O bus |
| io_rdata | input | 32 | Read data from the I/O bus |
| err | output | 1 | Illegal-size request refused |
| rsp_valid | output | 1 | Read response to the CPU side |
| rsp_data | output | 32 | Masked read data |

## Verification
The I/O access fields and `err` are registered once, so they are due on the cycle after the request edge. The bench drives each request on a falling edge and compares on the next falling edge, after exactly one rising edge. On selected vectors it waits one more falling edge to confirm that `io_valid` has dropped and that a later mode change left `io_addr` untouched. Read responses also take one register stage: `io_rvalid` is driven on a falling edge, and `rsp_data` is compared one falling edge later against a mask computed from the size of the last read the bench issued.

// File: rtl/dio_xlate.sv
module dio_xlate #(
  parameter logic [31:0] WIN_BASE = 32'h8000_0000,
  parameter int          WIN_AW   = 23,
  parameter logic [31:0] IO_BASE  = 32'h8000_0000,
  parameter int          PORT_W   = 16,
  parameter int          GRP_W    = 5,
  parameter int          PAGE_W   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        map_sparse,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        io_valid,
  output logic        io_write,
  output logic [31:0] io_addr,
  output logic [2:0]  io_size,
  output logic [31:0] io_wdata,
  input  logic        io_rvalid,
  input  logic [31:0] io_rdata,
  output logic        err,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);
  localparam int SPG_W = PORT_W - GRP_W;

  function automatic logic [31:0] lane_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    lane_mask = 32'h0000_00FF;
      3'd2:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  logic        hit, legal, take, refuse;
  logic [31:0] port_c, port_s, port;
  logic [2:0]  rd_size;

  assign hit    = req_addr[31:WIN_AW] == WIN_BASE[31:WIN_AW];
  assign legal  = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign take   = req_valid && hit && legal;
  assign refuse = req_valid && hit && !legal;

  assign port_c = 32'(req_addr[PORT_W-1:0]);
  assign port_s = 32'({req_addr[PAGE_W +: SPG_W], req_addr[GRP_W-1:0]});
  assign port   = map_sparse ? port_s : port_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_valid  <= 1'b0;
      err       <= 1'b0;
      io_write  <= 1'b0;
      io_addr   <= '0;
      io_size   <= '0;
      io_wdata  <= '0;
      rd_size   <= 3'd4;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      io_valid  <= take;
      err       <= refuse;
      rsp_valid <= io_rvalid;
      if (take) begin
        io_write <= req_write;
        io_addr  <= IO_BASE + port;
        io_size  <= req_size;
        io_wdata <= req_write ? (req_wdata & lane_mask(req_size)) : '0;
        if (!req_write) rd_size <= req_size;
      end
      if (io_rvalid) rsp_data <= io_rdata & lane_mask(rd_size);
    end
  end
endmodule

module dio_xlate_chk #(
  parameter logic [31:0] WIN_BASE = 32'h8000_0000,
  parameter int          WIN_AW   = 23,
  parameter logic [31:0] IO_BASE  = 32'h8000_0000,
  parameter int          PORT_W   = 16,
  parameter int          GRP_W    = 5,
  parameter int          PAGE_W   = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        map_sparse,
  input logic        req_valid,
  input logic        req_write,
  input logic [31:0] req_addr,
  input logic [2:0]  req_size,
  input logic        io_valid,
  input logic        io_write,
  input logic [31:0] io_addr,
  input logic [2:0]  io_size,
  input logic [31:0] io_wdata,
  input logic        io_rvalid,
  input logic        err,
  input logic        rsp_valid
);
  localparam int SPG_W = PORT_W - GRP_W;
  logic win, ok_sz;
  assign win   = req_addr[31:WIN_AW] == WIN_BASE[31:WIN_AW];
  assign ok_sz = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

  p_contig_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win && ok_sz && !map_sparse) |=>
      io_addr == IO_BASE + 32'($past(req_addr[PORT_W-1:0])));

  p_sparse_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win && ok_sz && map_sparse) |=>
      io_addr == IO_BASE + 32'({$past(req_addr[PAGE_W +: SPG_W]), $past(req_addr[GRP_W-1:0])}));

  p_byte_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_size == 3'd1) |-> io_wdata[31:8] == 24'd0);

  p_illegal_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win && !ok_sz) |=> (err && !io_valid));

  p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !win) |=> (!io_valid && !err));

  p_rsp_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |=> rsp_valid);

  p_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win && ok_sz) |=> (io_valid && io_write == $past(req_write) && io_size == $past(req_size)));

  p_no_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!io_valid && !err));
endmodule

bind dio_xlate dio_xlate_chk #(
  .WIN_BASE(WIN_BASE), .WIN_AW(WIN_AW), .IO_BASE(IO_BASE),
  .PORT_W(PORT_W), .GRP_W(GRP_W), .PAGE_W(PAGE_W)
) chk (
  .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
  .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr), .io_size(io_size),
  .io_wdata(io_wdata), .io_rvalid(io_rvalid), .err(err), .rsp_valid(rsp_valid)
);

// File: tb/dio_xlate_test.sv
module dio_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_sparse = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = 3'd1;
  logic [31:0] req_wdata = '0;
  logic        io_valid, io_write, err, rsp_valid;
  logic [31:0] io_addr, io_wdata, rsp_data;
  logic [2:0]  io_size;
  logic        io_rvalid = 1'b0;
  logic [31:0] io_rdata = '0;

  int vectors = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dio_xlate uut (
    .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
    .io_rvalid(io_rvalid), .io_rdata(io_rdata), .err(err),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int sz);
    return (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_io(input logic [31:0] a, input bit sp);
    logic [31:0] off = a - 32'h8000_0000;
    if (sp) return 32'h8000_0000 + (off % 32) + ((off / 4096) % 2048) * 32;
    return 32'h8000_0000 + (off % 65536);
  endfunction

  task automatic issue(input logic [31:0] a, input bit wr, input int sz,
                       input logic [31:0] d, input bit sp, input string tag);
    @(negedge clk);
    map_sparse = sp; req_valid = 1; req_write = wr; req_addr = a;
    req_size = 3'(sz); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check(io_valid === 1'b1 && err === 1'b0, {tag, " R10 issued"}, {30'd0, io_valid, err}, 32'h2);
    check(io_addr === exp_io(a, sp), tag, io_addr, exp_io(a, sp));
    check(io_write === wr && io_size === 3'(sz), {tag, " R10 dir/size"}, {28'd0, io_write, io_size}, {28'd0, wr, 3'(sz)});
    if (wr) check(io_wdata === (d & msk(sz)), "R4 wdata mask", io_wdata, d & msk(sz));
  endtask

  task automatic refused(input logic [31:0] a, input int sz, input bit exp_err, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_size = 3'(sz); req_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    req_valid = 0;
    check(io_valid === 1'b0 && err === exp_err, tag, {30'd0, io_valid, err}, {30'd0, 1'b0, exp_err});
    @(negedge clk);
    check(err === 1'b0, {tag, " single pulse"}, {31'd0, err}, 32'd0);
  endtask

  task automatic read_back(input int sz, input logic [31:0] d);
    issue(32'h8000_0100, 0, sz, 0, 0, "R8 read issue R1");
    io_rvalid = 1; io_rdata = d;
    @(negedge clk);
    io_rvalid = 0;
    check(rsp_valid === 1'b1 && rsp_data === (d & msk(sz)), "R8 read data", rsp_data, d & msk(sz));
    @(negedge clk);
    check(rsp_valid === 1'b0, "R8 single response", {31'd0, rsp_valid}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(io_valid === 0 && err === 0 && rsp_valid === 0, "R9 reset state",
          {29'd0, io_valid, err, rsp_valid}, 32'd0);
    rst_n = 1;

    for (int k = 0; k < 1024; k++) begin
      logic [31:0] a = 32'h8000_0000 + ((k * 32'h1F3D7) & 32'h7F_FFFF);
      int sz = (k % 3 == 0) ? 1 : (k % 3 == 1) ? 2 : 4;
      issue(a, k[0], sz, k * 32'h9E37_79B9, 0, "R1 contiguous");
    end

    for (int p = 0; p < 2048; p++) begin
      logic [31:0] a = 32'h8000_0000 + (p << 12) + ((p * 37) & 32'hFE0) + (p % 32);
      int sz = (p % 3 == 0) ? 4 : (p % 3 == 1) ? 1 : 2;
      issue(a, ~p[0], sz, p * 32'h0101_3579, 1, "R2 sparse");
    end

    for (int s = 0; s < 2; s++) begin
      issue(32'h8000_0003, 1, 4, 32'h1122_3344, s[0], "R6 unaligned word");
      issue(32'h807F_FFFF, 1, 2, 32'hAABB_CCDD, s[0], "R6 unaligned half");
      issue(32'h8012_3FFF, 0, 4, 0, s[0], "R6 unaligned read");
    end

    for (int k = 0; k < 16; k++)
      issue(32'h8000_0000 + k * 32'h0004_5A63, 1, 1, k, k[0], "R3 mode alternates");

    @(negedge clk);
    map_sparse = 1; req_valid = 1; req_write = 1; req_addr = 32'h8003_4567; req_size = 3'd2; req_wdata = 32'h55;
    @(negedge clk);
    req_valid = 0; map_sparse = 0;
    @(negedge clk);
    check(io_valid === 1'b0, "R10 valid one cycle", {31'd0, io_valid}, 32'd0);
    check(io_addr === exp_io(32'h8003_4567, 1), "R3 in-flight keeps map", io_addr, exp_io(32'h8003_4567, 1));

    for (int s = 0; s < 2; s++) begin
      map_sparse = s[0];
      refused(32'h8000_1234, 0, 1, "R5 size 0");
      refused(32'h8000_1234, 3, 1, "R5 size 3");
      refused(32'h8000_1234, 5, 1, "R5 size 5");
      refused(32'h8000_1234, 6, 1, "R5 size 6");
      refused(32'h8000_1234, 7, 1, "R5 size 7");
      refused(32'h7FFF_FFFC, 4, 0, "R7 below window");
      refused(32'h8080_0000, 4, 0, "R7 above window");
      refused(32'hC000_0000, 1, 0, "R7 far away");
      refused(32'h0000_0000, 3, 0, "R7 miss with illegal size");
    end

    read_back(1, 32'hCAFE_F00D);
    read_back(2, 32'h1234_5678);
    read_back(4, 32'h89AB_CDEF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule